// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a running wall-clock time as a 48-bit seconds count, a nanoseconds count that always stays below one billion, and a 16-bit binary fraction of a nanosecond. On every clock cycle it adds a step size to the nanosecond-plus-fraction accumulator. The step is expressed in fixed-point nanoseconds, with sixteen fraction bits. When the nanoseconds reach one billion they fold back and the seconds count advances.

Two corrections act on the step. An offset correction replaces the nominal step with a temporary step for a programmed number of cycles. The count of cycles still to go can be read back, and it reaches zero when the correction is done. A drift correction adds a small fractional amount once every N cycles. This lets a clock whose frequency does not divide evenly into nanoseconds keep exact long-term time. A load strobe sets the time outright.

Top module: `tod_counter`

## Requirements
- R1: Each cycle without a load, the 20-bit step (bits 15:0 are the fraction in units of 2^-16 ns, bits 19:16 are whole nanoseconds) is added to the {nanoseconds, fraction} accumulator, and the carry out of the fraction goes into nanoseconds.
- R2: While the remaining adjust count is nonzero, the adjust step replaces the nominal step for that cycle, and the count drops by one per cycle until it reads zero.
- R3: An adjust-count write strobe loads the supplied count, which takes effect from the following cycle. A write of zero cancels any correction in progress.
- R4: With a nonzero drift rate N, the 16-bit drift amount (units of 2^-16 ns) is added once every N cycles. The first addition comes N cycles after the cycle counter leaves zero, and the counter then restarts at zero.
- R5: A drift rate of zero disables the drift addition and holds the cycle counter at zero.
- R6: When nanoseconds reach or pass 1,000,000,000, that value is subtracted and seconds increment. Seconds wrap modulo 2^48.
- R7: A load strobe replaces seconds and nanoseconds and clears the fraction, taking precedence over that cycle's step. The adjust countdown and the drift counter keep running during a load.
- R8: After reset, time and fraction are zero, the nominal step is the parameter default (8.0 ns), the adjust count is zero and the drift counter is zero.
- R9: A step write strobe replaces the nominal step, which is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_wr_i | input | 1 | Write strobe for the nominal step |
| step_i | input | 20 | New nominal step, 4.16 fixed-point ns |
| adj_step_i | input | 20 | Step used while an offset correction runs |
| adj_wr_i | input | 1 | Write strobe for the adjust count |
| adj_count_i | input | 20 | Number of cycles that use the adjust step |
| drift_amt_i | input | 16 | Drift amount in 2^-16 ns |
| drift_rate_i | input | 16 | Drift period in cycles, 0 disables |
| load_i | input | 1 | Load strobe for a new time |
| load_sec_i | input | 48 | Seconds to load |
| load_ns_i | input | 30 | Nanoseconds to load, below 1e9 |
| sec_o | output | 48 | Live seconds |
| ns_o | output | 30 | Live nanoseconds |
| frac_o | output | 16 | Live sub-nanosecond fraction |
| adj_cnt_o | output | 20 | Remaining adjust cycles |

## Verification
The assertions take for granted that any loaded nanosecond value is below one billion. They also rely on the largest step plus the drift amount being far below one second, so that one cycle can cause at most one fold-back. The stimulus keeps loaded nanoseconds inside that range and often picks values just under the limit to force the fold-back. Steps and drift values cover their full widths, which stay tiny next to a second.

// File: rtl/tod_pkg.sv
package tod_pkg;
   parameter int unsigned NS_PER_SEC = 1_000_000_000;

   typedef enum logic {
      SRC_NOMINAL = 1'b0,
      SRC_ADJUST  = 1'b1
   } step_src_e;
endpackage

// File: rtl/tod_step_sel.sv
module tod_step_sel
   import tod_pkg::*;
#(
   parameter int PER_W       = 20,
   parameter int CNT_W       = 20,
   parameter logic [PER_W-1:0] RESET_STEP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_wr_i,
   input  logic [PER_W-1:0] step_i,
   input  logic [PER_W-1:0] adj_step_i,
   input  logic             adj_wr_i,
   input  logic [CNT_W-1:0] adj_count_i,
   output logic [PER_W-1:0] inc_o,
   output logic [CNT_W-1:0] adj_cnt_o
);
   logic [PER_W-1:0] nom_q;
   logic [CNT_W-1:0] cnt_q;
   step_src_e        src;

   always_comb begin
      src   = (cnt_q != '0) ? SRC_ADJUST : SRC_NOMINAL;
      inc_o = (src == SRC_ADJUST) ? adj_step_i : nom_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nom_q <= RESET_STEP;
         cnt_q <= '0;
      end else begin
         if (step_wr_i) nom_q <= step_i;
         if (adj_wr_i)
            cnt_q <= adj_count_i;
         else if (src == SRC_ADJUST)
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign adj_cnt_o = cnt_q;
endmodule

// File: rtl/tod_drift.sv
module tod_drift #(
   parameter int DRIFT_W  = 16,
   parameter int RATE_W   = 16,
   parameter bit DRIFT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DRIFT_W-1:0] amt_i,
   input  logic [RATE_W-1:0]  rate_i,
   output logic [DRIFT_W-1:0] add_o
);
   generate
      if (DRIFT_EN) begin : g_drift
         logic [RATE_W-1:0] cyc_q;
         logic              hit;

         always_comb begin
            hit   = (rate_i != '0) && (cyc_q >= rate_i - RATE_W'(1));
            add_o = hit ? amt_i : '0;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               cyc_q <= '0;
            else if (rate_i == '0 || hit)
               cyc_q <= '0;
            else
               cyc_q <= cyc_q + RATE_W'(1);
         end
      end else begin : g_nodrift
         assign add_o = '0;
      end
   endgenerate
endmodule

// File: rtl/tod_accum.sv
module tod_accum
   import tod_pkg::*;
#(
   parameter int SEC_W   = 48,
   parameter int NS_W    = 30,
   parameter int FRAC_W  = 16,
   parameter int PER_W   = 20,
   parameter int DRIFT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PER_W-1:0]   inc_i,
   input  logic [DRIFT_W-1:0] drift_i,
   input  logic               load_i,
   input  logic [SEC_W-1:0]   load_sec_i,
   input  logic [NS_W-1:0]    load_ns_i,
   output logic [SEC_W-1:0]   sec_o,
   output logic [NS_W-1:0]    ns_o,
   output logic [FRAC_W-1:0]  frac_o
);
   localparam int ACC_W = NS_W + FRAC_W;
   localparam int SUM_W = ACC_W + 1;
   localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

   logic [SEC_W-1:0]  sec_q;
   logic [NS_W-1:0]   ns_q;
   logic [FRAC_W-1:0] fr_q;
   logic [SUM_W-1:0]  sum;
   logic [NS_W:0]     ns_raw;
   logic [NS_W:0]     ns_nx;
   logic              wrap;

   always_comb begin
      sum    = SUM_W'({ns_q, fr_q}) + SUM_W'(inc_i) + SUM_W'(drift_i);
      ns_raw = sum[SUM_W-1:FRAC_W];
      wrap   = (ns_raw >= NS_LIM);
      ns_nx  = wrap ? (ns_raw - NS_LIM) : ns_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0;
         ns_q  <= '0;
         fr_q  <= '0;
      end else if (load_i) begin
         sec_q <= load_sec_i;
         ns_q  <= load_ns_i;
         fr_q  <= '0;
      end else begin
         ns_q <= ns_nx[NS_W-1:0];
         fr_q <= sum[FRAC_W-1:0];
         if (wrap) sec_q <= sec_q + SEC_W'(1);
      end
   end

   assign sec_o  = sec_q;
   assign ns_o   = ns_q;
   assign frac_o = fr_q;
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
   parameter int SEC_W    = 48,
   parameter int NS_W     = 30,
   parameter int FRAC_W   = 16,
   parameter int PER_W    = 20,
   parameter int CNT_W    = 20,
   parameter int DRIFT_W  = 16,
   parameter int RATE_W   = 16,
   parameter bit DRIFT_EN = 1'b1,
   parameter logic [PER_W-1:0] RESET_STEP = PER_W'(32'h0008_0000)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_wr_i,
   input  logic [PER_W-1:0]   step_i,
   input  logic [PER_W-1:0]   adj_step_i,
   input  logic               adj_wr_i,
   input  logic [CNT_W-1:0]   adj_count_i,
   input  logic [DRIFT_W-1:0] drift_amt_i,
   input  logic [RATE_W-1:0]  drift_rate_i,
   input  logic               load_i,
   input  logic [SEC_W-1:0]   load_sec_i,
   input  logic [NS_W-1:0]    load_ns_i,
   output logic [SEC_W-1:0]   sec_o,
   output logic [NS_W-1:0]    ns_o,
   output logic [FRAC_W-1:0]  frac_o,
   output logic [CNT_W-1:0]   adj_cnt_o
);
   generate
      if (NS_W < 30) begin : g_bad_ns
         $error("NS_W must hold one billion");
      end
      if (PER_W <= FRAC_W || PER_W - FRAC_W > 16) begin : g_bad_per
         $error("step needs whole-ns bits and must stay far below one second");
      end
      if (DRIFT_W > FRAC_W + 8) begin : g_bad_drift
         $error("drift amount too wide");
      end
   endgenerate

   logic [PER_W-1:0]   inc;
   logic [DRIFT_W-1:0] drift_add;

   tod_step_sel #(
      .PER_W(PER_W), .CNT_W(CNT_W), .RESET_STEP(RESET_STEP)
   ) u_sel (
      .clk(clk), .rst_n(rst_n),
      .step_wr_i(step_wr_i), .step_i(step_i), .adj_step_i(adj_step_i),
      .adj_wr_i(adj_wr_i), .adj_count_i(adj_count_i),
      .inc_o(inc), .adj_cnt_o(adj_cnt_o)
   );

   tod_drift #(
      .DRIFT_W(DRIFT_W), .RATE_W(RATE_W), .DRIFT_EN(DRIFT_EN)
   ) u_drift (
      .clk(clk), .rst_n(rst_n),
      .amt_i(drift_amt_i), .rate_i(drift_rate_i), .add_o(drift_add)
   );

   tod_accum #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
      .PER_W(PER_W), .DRIFT_W(DRIFT_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n),
      .inc_i(inc), .drift_i(drift_add),
      .load_i(load_i), .load_sec_i(load_sec_i), .load_ns_i(load_ns_i),
      .sec_o(sec_o), .ns_o(ns_o), .frac_o(frac_o)
   );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
   import tod_pkg::*;
#(
   parameter int SEC_W = 48,
   parameter int NS_W  = 30,
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic [SEC_W-1:0] load_sec_i,
   input logic [NS_W-1:0]  load_ns_i,
   input logic             adj_wr_i,
   input logic [CNT_W-1:0] adj_count_i,
   input logic [SEC_W-1:0] sec_o,
   input logic [NS_W-1:0]  ns_o,
   input logic [CNT_W-1:0] adj_cnt_o
);
   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_cnt_o != '0 && !adj_wr_i) |=> adj_cnt_o == $past(adj_cnt_o) - CNT_W'(1));

   a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_cnt_o == '0 && !adj_wr_i) |=> adj_cnt_o == '0);

   a_r3_count_write: assert property (@(posedge clk) disable iff (!rst_n)
      adj_wr_i |=> adj_cnt_o == $past(adj_count_i));

   a_r7_load_time: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sec_o == $past(load_sec_i) && ns_o == $past(load_ns_i)));

   a_r6_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
      ns_o < NS_W'(NS_PER_SEC));

   a_r6_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + SEC_W'(1)));
endmodule

bind tod_counter tod_counter_chk #(
   .SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_sec_i(load_sec_i),
   .load_ns_i(load_ns_i), .adj_wr_i(adj_wr_i), .adj_count_i(adj_count_i),
   .sec_o(sec_o), .ns_o(ns_o), .adj_cnt_o(adj_cnt_o)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
   localparam longint unsigned SEC_MASK = 64'h0000_FFFF_FFFF_FFFF;
   localparam longint unsigned BILLION  = 64'd1_000_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_wr_i = 1'b0;
   logic [19:0] step_i = '0;
   logic [19:0] adj_step_i = '0;
   logic        adj_wr_i = 1'b0;
   logic [19:0] adj_count_i = '0;
   logic [15:0] drift_amt_i = '0;
   logic [15:0] drift_rate_i = '0;
   logic        load_i = 1'b0;
   logic [47:0] load_sec_i = '0;
   logic [29:0] load_ns_i = '0;
   logic [47:0] sec_o;
   logic [29:0] ns_o;
   logic [15:0] frac_o;
   logic [19:0] adj_cnt_o;

   always #4 clk = ~clk;

   tod_counter dut (
      .clk(clk), .rst_n(rst_n), .step_wr_i(step_wr_i), .step_i(step_i),
      .adj_step_i(adj_step_i), .adj_wr_i(adj_wr_i), .adj_count_i(adj_count_i),
      .drift_amt_i(drift_amt_i), .drift_rate_i(drift_rate_i), .load_i(load_i),
      .load_sec_i(load_sec_i), .load_ns_i(load_ns_i), .sec_o(sec_o), .ns_o(ns_o),
      .frac_o(frac_o), .adj_cnt_o(adj_cnt_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   longint unsigned m_sec, m_ns, m_fr, m_step, m_adj, m_dc;

   task automatic check(input string tag, input string what,
                        input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_sec = 0; m_ns = 0; m_fr = 0; m_step = 64'h8_0000; m_adj = 0; m_dc = 0;
   endfunction

   function automatic void model_step();
      longint unsigned inc, dadd, tot;
      bit hit;
      inc  = (m_adj != 0) ? adj_step_i : m_step;
      hit  = (drift_rate_i != 0) && (m_dc >= longint'(drift_rate_i) - 1);
      dadd = hit ? drift_amt_i : 0;
      m_dc = (drift_rate_i == 0 || hit) ? 0 : m_dc + 1;
      if (load_i) begin
         m_sec = load_sec_i; m_ns = load_ns_i; m_fr = 0;
      end else begin
         tot  = (m_ns << 16) + m_fr + inc + dadd;
         m_fr = tot & 64'hFFFF;
         m_ns = tot >> 16;
         if (m_ns >= BILLION) begin
            m_ns  = m_ns - BILLION;
            m_sec = (m_sec + 1) & SEC_MASK;
         end
      end
      if (adj_wr_i) m_adj = adj_count_i;
      else if (m_adj != 0) m_adj = m_adj - 1;
      if (step_wr_i) m_step = step_i;
   endfunction

   task automatic compare_all(input string tag);
      check(tag, "sec", sec_o, m_sec);
      check(tag, "ns", ns_o, m_ns);
      check(tag, "frac", frac_o, m_fr);
      check(tag, "adj_cnt", adj_cnt_o, m_adj);
   endtask

   task automatic tick(input string tag);
      model_step();
      @(posedge clk);
      #1;
      step_wr_i = 1'b0; adj_wr_i = 1'b0; load_i = 1'b0;
      compare_all(tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      compare_all("R8");
      rst_n = 1'b1;
      ticks(5, "R8/R1");
      check("R8", "ns after 5 default steps", ns_o, 40);

      // R9 / R1: new step with fraction
      step_i = 20'h1_8000; step_wr_i = 1'b1;
      tick("R9");
      ticks(4, "R9/R1");
      check("R1", "fraction after 1.5ns steps", frac_o, 0);

      step_i = 20'h0_4001; step_wr_i = 1'b1;
      ticks(6, "R1");

      // R7: load clears fraction
      load_sec_i = 48'd5; load_ns_i = 30'd999_999_990; load_i = 1'b1;
      tick("R7");
      check("R7", "fraction cleared by load", frac_o, 0);
      check("R7", "ns loaded", ns_o, 999_999_990);
      step_i = 20'h8_0000; step_wr_i = 1'b1;
      ticks(4, "R6");
      check("R6", "seconds advanced past rollover", sec_o, 6);

      // R6: seconds wrap
      load_sec_i = 48'hFFFF_FFFF_FFFF; load_ns_i = 30'd999_999_995; load_i = 1'b1;
      tick("R7");
      ticks(2, "R6");
      check("R6", "seconds wrapped", sec_o, 0);

      // R2/R3: offset correction
      adj_step_i = 20'h5_0000; adj_count_i = 20'd3; adj_wr_i = 1'b1;
      tick("R3");
      check("R3", "count loaded", adj_cnt_o, 3);
      ticks(4, "R2");
      check("R2", "count finished", adj_cnt_o, 0);
      adj_count_i = 20'd10; adj_wr_i = 1'b1;
      ticks(3, "R3");
      adj_count_i = 20'd0; adj_wr_i = 1'b1;
      tick("R3");
      check("R3", "zero write cancels", adj_cnt_o, 0);
      ticks(2, "R3");

      // R4 drift every 4 cycles; R5 zero rate
      step_i = 20'h1_0000; step_wr_i = 1'b1;
      load_sec_i = 48'd1; load_ns_i = 30'd0; load_i = 1'b1;
      drift_amt_i = 16'h4000; drift_rate_i = 16'd4;
      tick("R4");
      ticks(8, "R4");
      drift_rate_i = 16'd0; drift_amt_i = 16'hFFFF;
      load_ns_i = 30'd100; load_i = 1'b1;
      tick("R5");
      ticks(10, "R5");
      check("R5", "no drift with zero rate", frac_o, 0);

      // Random phase
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 3) begin
            step_i = 20'($urandom); step_wr_i = 1'b1;
         end else if (r < 6) begin
            adj_step_i = 20'($urandom);
            adj_count_i = ($urandom_range(0, 3) == 0) ? 20'd0 : 20'($urandom_range(1, 40));
            adj_wr_i = 1'b1;
         end else if (r < 8) begin
            drift_amt_i = 16'($urandom);
            drift_rate_i = 16'($urandom_range(0, 12));
         end else if (r < 10) begin
            load_sec_i = {16'($urandom), 32'($urandom)};
            load_ns_i = ($urandom_range(0, 1) == 1) ? 30'(999_999_900 + $urandom_range(0, 99))
                                                   : 30'($urandom_range(0, 999_999_999));
            load_i = 1'b1;
         end
         tick("R1/R2/R4/R6");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule